// File: doc/BRIEF.md
# Sequential Control-Word Display Loader

This block is the write side of an eight-digit multiplexed LED display controller. A host drives an 8-bit bus together with two asynchronous strobes: an active-low write strobe and a mode select. A write done with the mode select high is a control word. It sets the display mode bits that the scan driver uses: run or shutdown, decode enable, and hexadecimal or Code B font. It can also arm the loader. A write done with the mode select low is a data byte. Each data byte goes to the next location of an eight-entry display memory, starting at location 0.

No address bus exists. Once armed, the loader accepts exactly eight data bytes and then locks. Any further data writes are dropped until a new control word arrives, so one digit cannot be updated alone. While the loader is armed, it asks the scan driver to blank the display. When decoding is enabled, each stored byte keeps only the decimal-point bit and the 4-bit character code.

The strobes and bus are brought into the clock domain through a synchronizer chain. A write takes effect on the rising edge of the write strobe, that is, when it returns high after being low. All outputs are registered.

Top module: `seqdl_loader`

## Requirements
- R1: After a synchronous reset, `cfg_run`, `cfg_decode`, `cfg_hex` and `disp_blank` are 0, and no memory write occurs until an armed data write.
- R2: In a control write, the bits map as follows:
  - `cfg_run` takes bus bit 4 (1 = run, 0 = shutdown).
  - `cfg_decode` takes the inverse of bus bit 5 (bit 5 low enables decoding).
  - `cfg_hex` takes bus bit 6 (1 = hexadecimal, 0 = Code B).
  - Bus bits 3..0 have no effect.
- R3: A control write with bus bit 7 set arms the loader and raises `disp_blank`. The next eight data writes each produce one `mem_we` pulse, at addresses 0, 1, ..., 7 in that order.
- R4: The eighth data write lowers `disp_blank` in the same cycle as its `mem_we` pulse. Further data writes produce no `mem_we` until a new control word is written.
- R5: Data writes while the loader is not armed produce no `mem_we`. This covers the state after reset and the state after a control word with bit 7 clear.
- R6: A control word with bit 7 clear updates the mode bits and disarms the loader. A control word with bit 7 set restarts loading at address 0, even in the middle of a sequence.
- R7: When `cfg_decode` is 1, the stored byte carries bus bits 7 and 3..0 and has bits 6..4 forced to 0. When `cfg_decode` is 0, the stored byte equals the bus byte.
- R8: A write commits only on a low-to-high transition of the write strobe. Holding the strobe low commits nothing. The resulting output change appears at the second rising clock edge after the first edge that samples the strobe high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_n | input | 1 | Asynchronous write strobe, active low; commits on its rising edge |
| ctl_sel | input | 1 | Asynchronous mode select: 1 = control word, 0 = data byte |
| bus_in | input | 8 | Host data bus |
| mem_we | output | 1 | Display memory write enable, one cycle per stored byte |
| mem_addr | output | 3 | Display memory write address |
| mem_wdata | output | 8 | Display memory write data |
| cfg_run | output | 1 | 1 = display running, 0 = shutdown |
| cfg_decode | output | 1 | 1 = stored bytes are decoded to a 7-segment font |
| cfg_hex | output | 1 | 1 = hexadecimal font, 0 = Code B font |
| disp_blank | output | 1 | Display blank request while the loader is armed |

## Verification
Every result comes from a three-register path: two synchronizer flops, then the output register. So a `mem_we` pulse or a mode change lands on the second clock edge after the edge that first sees the strobe high. The bench drives the strobe on falling edges and, in one directed case, samples `mem_we` on the first, second and third falling edges after release. It expects 0, 0 and 1. All other checks wait five cycles after each release, and only then compare the mode bits or the memory image. That image is rebuilt at falling edges from the observed write-port pulses.

// File: rtl/seqdl_pkg.sv
package seqdl_pkg;

  // Control-word bit positions (decoded by the scan side as well)
  localparam int CW_RUN_BIT = 4;
  localparam int CW_RAW_BIT = 5;
  localparam int CW_HEX_BIT = 6;
  localparam int CW_ARM_BIT = 7;
  localparam int DP_BIT     = 7;

  typedef struct packed {
    logic run;
    logic decode_en;
    logic hex_sel;
  } disp_mode_t;

  // Keep decimal point and 4-bit code when decoding; raw byte otherwise
  function automatic logic [7:0] shape_byte(input logic [7:0] b, input logic dec);
    shape_byte = dec ? {b[DP_BIT], 3'b000, b[3:0]} : b;
  endfunction

endpackage

// File: rtl/seqdl_sync.sv
module seqdl_sync #(
  parameter int          W       = 1,
  parameter int          STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] st [STAGES];

  always_ff @(posedge clk) begin
    if (rst) st[0] <= RST_VAL;
    else     st[0] <= d;
  end

  for (genvar i = 1; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) st[i] <= RST_VAL;
      else     st[i] <= st[i-1];
    end
  end

  assign q = st[STAGES-1];

endmodule

// File: rtl/seqdl_edge.sv
module seqdl_edge (
  input  logic clk,
  input  logic rst,
  input  logic level_in,
  output logic rise
);

  logic prev;

  // idle level of the strobe is high, so reset prev high
  always_ff @(posedge clk) begin
    if (rst) prev <= 1'b1;
    else     prev <= level_in;
  end

  assign rise = level_in & ~prev;

endmodule

// File: rtl/seqdl_seq.sv
module seqdl_seq
  import seqdl_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int DATA_W = 8,
  parameter int AW     = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              commit,
  input  logic              is_ctrl,
  input  logic [DATA_W-1:0] bus,
  output logic              mem_we,
  output logic [AW-1:0]     mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output disp_mode_t        mode,
  output logic              armed
);

  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [AW-1:0] wr_ptr;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode      <= '0;
      armed     <= 1'b0;
      wr_ptr    <= '0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
    end else begin
      mem_we <= 1'b0;
      if (commit) begin
        if (is_ctrl) begin
          mode.run       <= bus[CW_RUN_BIT];
          mode.decode_en <= ~bus[CW_RAW_BIT];
          mode.hex_sel   <= bus[CW_HEX_BIT];
          armed          <= bus[CW_ARM_BIT];
          if (bus[CW_ARM_BIT]) wr_ptr <= '0;
        end else if (armed) begin
          mem_we    <= 1'b1;
          mem_addr  <= wr_ptr;
          mem_wdata <= shape_byte(bus, mode.decode_en);
          if (wr_ptr == LAST) begin
            armed  <= 1'b0;
            wr_ptr <= '0;
          end else begin
            wr_ptr <= wr_ptr + 1'b1;
          end
        end
      end
    end
  end

endmodule

// File: rtl/seqdl_loader.sv
module seqdl_loader
  import seqdl_pkg::*;
#(
  parameter int DEPTH       = 8,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2,
  localparam int AW         = $clog2(DEPTH),
  localparam int SW         = DATA_W + 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_n,
  input  logic              ctl_sel,
  input  logic [DATA_W-1:0] bus_in,
  output logic              mem_we,
  output logic [AW-1:0]     mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              cfg_run,
  output logic              cfg_decode,
  output logic              cfg_hex,
  output logic              disp_blank
);

  logic [SW-1:0] raw_in, synced;
  logic          wr_s, sel_s, commit;
  logic [DATA_W-1:0] bus_s;
  disp_mode_t    mode;
  logic          armed;

  assign raw_in = {wr_n, ctl_sel, bus_in};

  seqdl_sync #(
    .W(SW), .STAGES(SYNC_STAGES), .RST_VAL({1'b1, {(SW-1){1'b0}}})
  ) u_sync (
    .clk(clk), .rst(rst), .d(raw_in), .q(synced)
  );

  assign wr_s  = synced[SW-1];
  assign sel_s = synced[SW-2];
  assign bus_s = synced[DATA_W-1:0];

  seqdl_edge u_edge (
    .clk(clk), .rst(rst), .level_in(wr_s), .rise(commit)
  );

  seqdl_seq #(
    .DEPTH(DEPTH), .DATA_W(DATA_W), .AW(AW)
  ) u_seq (
    .clk(clk), .rst(rst), .commit(commit), .is_ctrl(sel_s), .bus(bus_s),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mode(mode), .armed(armed)
  );

  assign cfg_run    = mode.run;
  assign cfg_decode = mode.decode_en;
  assign cfg_hex    = mode.hex_sel;
  assign disp_blank = armed;

endmodule

// File: rtl/seqdl_checker.sv
module seqdl_checker #(
  parameter int DEPTH = 8,
  localparam int AW   = $clog2(DEPTH)
) (
  input logic          clk,
  input logic          rst,
  input logic          mem_we,
  input logic [AW-1:0] mem_addr,
  input logic [7:0]    mem_wdata,
  input logic          cfg_run,
  input logic          cfg_decode,
  input logic          disp_blank
);

  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [AW-1:0] last_addr;

  always_ff @(posedge clk) begin
    if (rst)         last_addr <= '0;
    else if (mem_we) last_addr <= mem_addr;
  end

  assert_reset_idle_R1: assert property (@(posedge clk)
    rst |=> (!cfg_run && !disp_blank && !mem_we));

  assert_we_needs_arm_R5: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> $past(disp_blank));

  assert_addr_step_R3: assert property (@(posedge clk) disable iff (rst)
    (mem_we && mem_addr != '0) |-> (mem_addr == last_addr + 1'b1));

  assert_unblank_on_last_R4: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> (disp_blank == (mem_addr != LAST)));

  assert_decode_mask_R7: assert property (@(posedge clk) disable iff (rst)
    (mem_we && cfg_decode) |-> (mem_wdata[6:4] == 3'b000));

  assert_single_pulse_R8: assert property (@(posedge clk) disable iff (rst)
    mem_we |=> !mem_we);

endmodule

bind seqdl_loader seqdl_checker #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst(rst), .mem_we(mem_we), .mem_addr(mem_addr),
  .mem_wdata(mem_wdata), .cfg_run(cfg_run), .cfg_decode(cfg_decode),
  .disp_blank(disp_blank)
);

// File: tb/seqdl_loader_tb.sv
module seqdl_loader_tb;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_n = 1'b1;
  logic       ctl_sel = 1'b0;
  logic [7:0] bus_in = 8'h00;
  logic       mem_we;
  logic [2:0] mem_addr;
  logic [7:0] mem_wdata;
  logic       cfg_run, cfg_decode, cfg_hex, disp_blank;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  int wr_count = 0;
  logic [7:0] shadow [8];
  int log_addr [64];
  logic done = 1'b0;

  always #10 clk = ~clk;

  seqdl_loader u_dut (
    .clk(clk), .rst(rst), .wr_n(wr_n), .ctl_sel(ctl_sel), .bus_in(bus_in),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .cfg_run(cfg_run), .cfg_decode(cfg_decode), .cfg_hex(cfg_hex),
    .disp_blank(disp_blank)
  );

  // observe the memory write port away from the active edge
  always @(negedge clk) begin
    cycles++;
    if (!rst && mem_we) begin
      shadow[mem_addr] = mem_wdata;
      log_addr[wr_count % 64] = int'(mem_addr);
      wr_count++;
    end
    if (cycles > 100000 && !done) begin
      errors++;
      $display("FAIL watchdog: run hung, actual %0d cycles expected < 100000", cycles);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic host_write(input logic sel, input logic [7:0] d);
    @(negedge clk);
    ctl_sel = sel;
    bus_in  = d;
    wr_n    = 1'b0;
    repeat (3) @(negedge clk);
    wr_n = 1'b1;
    repeat (5) @(negedge clk);
  endtask

  function automatic logic [7:0] expect_byte(input logic [7:0] d, input logic dec);
    return dec ? (d & 8'h8F) : d;
  endfunction

  initial begin
    int base;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    repeat (2) @(negedge clk);

    // R1 reset state
    chk(!cfg_run && !cfg_decode && !cfg_hex && !disp_blank, "R1 reset mode",
        int'({cfg_run, cfg_decode, cfg_hex, disp_blank}), 0);
    // R5 data writes before any arm are dropped
    host_write(1'b0, 8'h5A);
    host_write(1'b0, 8'h33);
    chk(wr_count == 0, "R5 write before arm", wr_count, 0);

    // R2 sweep of every control nibble, random low nibble
    for (int n = 0; n < 16; n++) begin
      logic [7:0] cw;
      cw = {n[3:0], 4'(n * 7 + 3)};
      host_write(1'b1, cw);
      chk(cfg_run == cw[4], "R2 run bit", int'(cfg_run), int'(cw[4]));
      chk(cfg_decode == !cw[5], "R2 decode bit", int'(cfg_decode), int'(!cw[5]));
      chk(cfg_hex == cw[6], "R2 hex bit", int'(cfg_hex), int'(cw[6]));
      chk(disp_blank == cw[7], "R3 blank follows arm", int'(disp_blank), int'(cw[7]));
    end

    // R3/R7 decoded load of eight bytes
    host_write(1'b1, 8'b1101_0000);
    base = wr_count;
    for (int i = 0; i < 8; i++) begin
      host_write(1'b0, 8'(i * 37 + 5) | 8'h70);
      if (i < 7) chk(disp_blank == 1'b1, "R3 blank during load", int'(disp_blank), 1);
    end
    chk(wr_count - base == 8, "R3 eight writes", wr_count - base, 8);
    for (int i = 0; i < 8; i++) begin
      chk(log_addr[(base + i) % 64] == i, "R3 address order", log_addr[(base + i) % 64], i);
      chk(shadow[i] == expect_byte(8'(i * 37 + 5) | 8'h70, 1'b1), "R7 decoded byte",
          int'(shadow[i]), int'(expect_byte(8'(i * 37 + 5) | 8'h70, 1'b1)));
    end
    chk(disp_blank == 1'b0, "R4 unblank after eighth", int'(disp_blank), 0);

    // R4 lockout after eight
    base = wr_count;
    host_write(1'b0, 8'hFF);
    host_write(1'b0, 8'h01);
    chk(wr_count == base, "R4 lockout", wr_count - base, 0);
    chk(shadow[0] == expect_byte(8'd5 | 8'h70, 1'b1), "R4 memory untouched",
        int'(shadow[0]), int'(expect_byte(8'd5 | 8'h70, 1'b1)));

    // R7 raw load (bit5 set = no decode), full bytes kept
    host_write(1'b1, 8'b1011_0000);
    chk(cfg_decode == 1'b0, "R7 raw mode", int'(cfg_decode), 0);
    base = wr_count;
    for (int i = 0; i < 8; i++) host_write(1'b0, 8'(255 - i * 29));
    for (int i = 0; i < 8; i++)
      chk(shadow[i] == 8'(255 - i * 29), "R7 raw byte", int'(shadow[i]), int'(8'(255 - i * 29)));

    // R6 disarm mid-load, then restart at 0
    host_write(1'b1, 8'b1001_0000);
    host_write(1'b0, 8'h11);
    host_write(1'b0, 8'h22);
    host_write(1'b1, 8'b0001_0000);
    chk(disp_blank == 1'b0 && cfg_run == 1'b1, "R6 disarm updates mode",
        int'({disp_blank, cfg_run}), 1);
    base = wr_count;
    host_write(1'b0, 8'h44);
    chk(wr_count == base, "R6 disarmed drop", wr_count - base, 0);
    host_write(1'b1, 8'b1001_0000);
    host_write(1'b0, 8'h55);
    host_write(1'b0, 8'h66);
    host_write(1'b1, 8'b1001_0000);
    base = wr_count;
    host_write(1'b0, 8'h77);
    chk(log_addr[base % 64] == 0, "R6 restart at zero", log_addr[base % 64], 0);

    // R8 latency and edge-only commit
    base = wr_count;
    @(negedge clk);
    ctl_sel = 1'b0;
    bus_in  = 8'h09;
    wr_n    = 1'b0;
    repeat (10) @(negedge clk);
    chk(wr_count == base, "R8 low level no commit", wr_count - base, 0);
    wr_n = 1'b1;
    @(negedge clk);
    chk(mem_we == 1'b0, "R8 edge 1", int'(mem_we), 0);
    @(negedge clk);
    chk(mem_we == 1'b0, "R8 edge 2", int'(mem_we), 0);
    @(negedge clk);
    chk(mem_we == 1'b1 && mem_addr == 3'd1, "R8 edge 3", int'(mem_we), 1);
    repeat (4) @(negedge clk);
    chk(wr_count == base + 1, "R8 one pulse", wr_count - base, 1);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule